// File: doc/BRIEF.md
# Flash command controller

This block is the control front end of a small parallel NOR-style flash model. A host drives active-low chip enable, output enable, write enable and reset pins. Write-enable rising edges with chip enable low are decoded as one- or two-cycle commands. The block tracks which view the data outputs present: the array, the identifier words or the status byte. It runs a simulated internal engine for block erase, word programming and block lock-bit changes. Each operation lasts a parameterised number of clock cycles, so simulation stays short.

A running erase can be suspended, so that other blocks can be read and programmed. A running word program can be suspended so that other words can be read. Pulling the reset pin low aborts whatever is running, returns the block to array reads and leaves the status at 80h. The ready/busy output lets a host wait without polling. The storage is a small register file with one lock bit per block. Programming can only clear bits, and erasing sets every word of a block to all ones.

Top module: `flash_cmd_if`

## Requirements
- R1: While `rpN` is low `ryBy` is high and outputs are disabled; on leaving reset the outputs show the array (no command needed) and status reads 80h.
- R2: Driving `rpN` low during a running operation aborts it: `ryBy` is high at the next clock and after release the status is 80h.
- R3: For RECOVER_CYCLES clocks after `rpN` rises, command writes are ignored.
- R4: `dataOe` is high only when `ceN`=0, `oeN`=0 and `rpN`=1; `dataOut` is zero whenever `dataOe` is low.
- R5: Code FFh selects array reads, 70h status reads (status in bits 7:0, upper bits zero), 90h identifier reads: word offset 0 of a block returns MFR_ID, offset 1 DEV_ID, offset 2 the block's lock bit in bit 0.
- R6: 20h then D0h at any address of a block holds `ryBy` low for exactly ERASE_CYCLES clocks, then every word of that block reads FFFFh and other blocks are unchanged.
- R7: 40h then a data word programs that address with `ryBy` low for exactly WRITE_CYCLES clocks; the new content is old AND data.
- R8: Status bit 7 = ready, bit 6 = erase suspended, bit 5 = erase error, bit 4 = write error, bit 2 = write suspended, bit 1 = locked block targeted, bits 3 and 0 zero. An unknown first code, or a 20h/60h setup followed by an invalid second code, sets bits 5 and 4. Code 50h clears bits 5, 4 and 1.
- R9: B0h during an erase stops it with `ryBy` high and status bits 7 and 6 set. Other blocks can then be read and programmed, and D0h resumes it. The erase's total busy time stays ERASE_CYCLES.
- R10: B0h during a word program stops it with `ryBy` high and status bits 7 and 2 set. Other words can then be read, and D0h resumes it. The total busy time stays WRITE_CYCLES.
- R11: 60h then 01h sets the target block's lock bit, and 60h then D0h clears all lock bits; each takes WRITE_CYCLES clocks. An erase or program aimed at a locked block does not start: it sets bit 1 plus bit 5 (erase) or bit 4 (program) and leaves the data unchanged.
- R12: An operation runs to completion with `ceN` held high.
- R13: While an operation runs, the outputs show the status byte whatever mode was selected, and every command except B0h is ignored.
- R14: Programming a word inside the block whose erase is suspended is refused with status bit 4 and no busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples all pins |
| rpN | input | 1 | Active-low reset / power-down |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable; its rising edge latches a command |
| addr | input | ADDR_W | Word address (top BLK_W bits select the block) |
| dataIn | input | DATA_W | Command code (bits 7:0) or program data |
| dataOut | output | DATA_W | Read data, zero when not enabled |
| dataOe | output | 1 | High when `dataOut` should be driven onto the bus |
| ryBy | output | 1 | High when ready, suspended or in reset; low while busy |

## Verification
The collisions that matter are a suspend or reset arriving while the engine is mid-count, and a program started inside an erase suspend. The bench issues B0h a few clocks into an erase and then runs a nested program in another block. It counts every low `ryBy` clock and requires the sum to equal ERASE_CYCLES plus WRITE_CYCLES, so no cycle is lost or repeated. Reset is dropped a few clocks into an erase: the bench requires `ryBy` high on the next clock, array reads afterwards, status 80h, and commands ignored until the recovery count has run out.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_ID     = 2'd1,
    MODE_STATUS = 2'd2
  } readMode_t;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_ERASE = 2'd1,
    PEND_WRITE = 2'd2,
    PEND_LOCK  = 2'd3
  } pend_t;

  typedef enum logic [1:0] {
    OP_WORD    = 2'd0,
    OP_LOCKSET = 2'd1,
    OP_LOCKCLR = 2'd2
  } opKind_t;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic memWr;
    logic blkErase;
    logic lockSet;
    logic lockClrAll;
  } strobe_t;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_WRITE      = 8'h40;
  localparam logic [7:0] CMD_WRITE_ALT  = 8'h10;
  localparam logic [7:0] CMD_LOCK       = 8'h60;
  localparam logic [7:0] CMD_LOCK_SET   = 8'h01;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int ADDR_W         = 6,
  parameter int BLK_W          = 2,
  parameter int ERASE_CYCLES   = 40,
  parameter int WRITE_CYCLES   = 8,
  parameter int RECOVER_CYCLES = 3
) (
  input  logic                    clk,
  input  logic                    rpN,
  input  logic                    ceN,
  input  logic                    weN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic [(1<<BLK_W)-1:0]   lockVec,
  output strobe_t                 strobe,
  output logic [ADDR_W-1:0]       opAddr,
  output logic [DATA_W-1:0]       opData,
  output readMode_t               effMode,
  output logic [7:0]              statusByte,
  output logic                    ryBy
);

  localparam int OFF_W = ADDR_W - BLK_W;
  localparam int ECW   = $clog2(ERASE_CYCLES + 1);
  localparam int WCW   = $clog2(WRITE_CYCLES + 1);
  localparam int RCW   = $clog2(RECOVER_CYCLES + 1);

  readMode_t          readMode;
  pend_t              pend;
  opKind_t            writeKind;
  logic               eraseActive, eraseSusp;
  logic               writeActive, writeSusp;
  logic [BLK_W-1:0]   eraseBlk;
  logic [ECW-1:0]     eraseCnt;
  logic [WCW-1:0]     writeCnt;
  logic [ADDR_W-1:0]  writeAddr;
  logic [DATA_W-1:0]  writeData;
  logic               eraseErr, writeErr, lockHit;
  logic [RCW-1:0]     recoverCnt;
  logic               weQ;

  logic               eraseRun, writeRun, busy, eraseDone, writeDone;
  logic               cmdValid, tgtLocked;
  logic [7:0]         cmd;
  logic [BLK_W-1:0]   tgtBlk;

  always_comb begin
    eraseRun  = eraseActive & ~eraseSusp & ~writeActive;
    writeRun  = writeActive & ~writeSusp;
    busy      = eraseRun | writeRun;
    eraseDone = eraseRun && (eraseCnt == '0);
    writeDone = writeRun && (writeCnt == '0);
    cmd       = dataIn[7:0];
    tgtBlk    = addr[ADDR_W-1:OFF_W];
    tgtLocked = lockVec[tgtBlk];
    cmdValid  = ~weQ & weN & ~ceN & (recoverCnt == '0);
  end

  always_comb begin
    strobe.blkErase   = eraseDone;
    strobe.memWr      = writeDone && (writeKind == OP_WORD);
    strobe.lockSet    = writeDone && (writeKind == OP_LOCKSET);
    strobe.lockClrAll = writeDone && (writeKind == OP_LOCKCLR);
    opAddr     = eraseDone ? {eraseBlk, {OFF_W{1'b0}}} : writeAddr;
    opData     = writeData;
    statusByte = {~busy, eraseSusp, eraseErr, writeErr, 1'b0, writeSusp, lockHit, 1'b0};
    effMode    = busy ? MODE_STATUS : readMode;
    ryBy       = ~busy;
  end

  always_ff @(posedge clk) begin
    if (!rpN) begin
      readMode    <= MODE_ARRAY;
      pend        <= PEND_NONE;
      writeKind   <= OP_WORD;
      eraseActive <= 1'b0;
      eraseSusp   <= 1'b0;
      writeActive <= 1'b0;
      writeSusp   <= 1'b0;
      eraseBlk    <= '0;
      eraseCnt    <= '0;
      writeCnt    <= '0;
      writeAddr   <= '0;
      writeData   <= '0;
      eraseErr    <= 1'b0;
      writeErr    <= 1'b0;
      lockHit     <= 1'b0;
      recoverCnt  <= RCW'(RECOVER_CYCLES);
      weQ         <= 1'b1;
    end else begin
      weQ <= weN;
      if (recoverCnt != '0) recoverCnt <= recoverCnt - 1'b1;

      if (eraseRun) begin
        if (eraseCnt == '0) eraseActive <= 1'b0;
        else                eraseCnt    <= eraseCnt - 1'b1;
      end
      if (writeRun) begin
        if (writeCnt == '0) writeActive <= 1'b0;
        else                writeCnt    <= writeCnt - 1'b1;
      end

      if (cmdValid) begin
        if (pend != PEND_NONE) begin
          pend     <= PEND_NONE;
          readMode <= MODE_STATUS;
          case (pend)
            PEND_ERASE: begin
              if (cmd != CMD_CONFIRM) begin
                eraseErr <= 1'b1; writeErr <= 1'b1;
              end else if (tgtLocked) begin
                eraseErr <= 1'b1; lockHit <= 1'b1;
              end else if (eraseActive || writeActive) begin
                eraseErr <= 1'b1; writeErr <= 1'b1;
              end else begin
                eraseActive <= 1'b1;
                eraseBlk    <= tgtBlk;
                eraseCnt    <= ECW'(ERASE_CYCLES - 1);
              end
            end
            PEND_WRITE: begin
              if (tgtLocked) begin
                writeErr <= 1'b1; lockHit <= 1'b1;
              end else if (writeActive || (eraseActive && tgtBlk == eraseBlk)) begin
                writeErr <= 1'b1;
              end else begin
                writeActive <= 1'b1;
                writeKind   <= OP_WORD;
                writeAddr   <= addr;
                writeData   <= dataIn;
                writeCnt    <= WCW'(WRITE_CYCLES - 1);
              end
            end
            PEND_LOCK: begin
              if (eraseActive || writeActive ||
                  (cmd != CMD_LOCK_SET && cmd != CMD_CONFIRM)) begin
                eraseErr <= 1'b1; writeErr <= 1'b1;
              end else begin
                writeActive <= 1'b1;
                writeKind   <= (cmd == CMD_LOCK_SET) ? OP_LOCKSET : OP_LOCKCLR;
                writeAddr   <= addr;
                writeCnt    <= WCW'(WRITE_CYCLES - 1);
              end
            end
            default: ;
          endcase
        end else if (busy) begin
          if (cmd == CMD_SUSPEND) begin
            if (writeRun) writeSusp <= 1'b1;
            else          eraseSusp <= 1'b1;
          end
        end else begin
          case (cmd)
            CMD_READ_ARRAY: readMode <= MODE_ARRAY;
            CMD_READ_ID:    readMode <= MODE_ID;
            CMD_READ_STAT:  readMode <= MODE_STATUS;
            CMD_CLR_STAT: begin
              eraseErr <= 1'b0; writeErr <= 1'b0; lockHit <= 1'b0;
            end
            CMD_ERASE:     begin pend <= PEND_ERASE; readMode <= MODE_STATUS; end
            CMD_WRITE,
            CMD_WRITE_ALT: begin pend <= PEND_WRITE; readMode <= MODE_STATUS; end
            CMD_LOCK:      begin pend <= PEND_LOCK;  readMode <= MODE_STATUS; end
            CMD_CONFIRM: begin
              readMode <= MODE_STATUS;
              if (writeSusp)                       writeSusp <= 1'b0;
              else if (eraseSusp && !writeActive)  eraseSusp <= 1'b0;
            end
            CMD_SUSPEND: ;
            default: begin eraseErr <= 1'b1; writeErr <= 1'b1; end
          endcase
        end
      end
    end
  end

  // R1
  reset_exit_chk: assert property (@(posedge clk)
    $rose(rpN) |-> (statusByte == 8'h80 && effMode == MODE_ARRAY && ryBy));

  // R2
  reset_abort_chk: assert property (@(posedge clk)
    !rpN |=> ryBy);

  // R3
  recover_quiet_chk: assert property (@(posedge clk) disable iff (!rpN)
    (recoverCnt != '0) |-> (pend == PEND_NONE && !writeActive && !eraseActive));

  // R9
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rpN)
    eraseSusp |=> $stable(eraseCnt));

  // R10
  write_susp_ready_chk: assert property (@(posedge clk) disable iff (!rpN)
    writeSusp |-> ryBy);

endmodule

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int              DATA_W = 16,
  parameter int              ADDR_W = 6,
  parameter int              BLK_W  = 2,
  parameter logic [DATA_W-1:0] MFR_ID = 16'h00B0,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h00E3
) (
  input  logic                  clk,
  input  logic                  rpN,
  input  logic                  ceN,
  input  logic                  oeN,
  input  logic [ADDR_W-1:0]     addr,
  input  strobe_t               strobe,
  input  logic [ADDR_W-1:0]     opAddr,
  input  logic [DATA_W-1:0]     opData,
  input  readMode_t             effMode,
  input  logic [7:0]            statusByte,
  output logic [(1<<BLK_W)-1:0] lockVec,
  output logic [DATA_W-1:0]     dataOut,
  output logic                  dataOe
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int OFF_W      = ADDR_W - BLK_W;
  localparam int BLK_WORDS  = 1 << OFF_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [BLK_W-1:0]  opBlk, rdBlk;
  logic [DATA_W-1:0] rdData;

  assign opBlk = opAddr[ADDR_W-1:OFF_W];
  assign rdBlk = addr[ADDR_W-1:OFF_W];

  // storage: erase fills a block with ones, programming only clears bits
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (strobe.blkErase && (i / BLK_WORDS) == int'(opBlk))
        mem[i] <= '1;
      else if (strobe.memWr && opAddr == ADDR_W'(i))
        mem[i] <= mem[i] & opData;
    end
  end

  // lock bits are non-volatile: untouched by reset
  always_ff @(posedge clk) begin
    if (strobe.lockClrAll)   lockVec <= '0;
    else if (strobe.lockSet) lockVec[opBlk] <= 1'b1;
  end

  always_comb begin
    case (effMode)
      MODE_ARRAY: rdData = mem[addr];
      MODE_ID: begin
        case (addr[1:0])
          2'd0:    rdData = MFR_ID;
          2'd1:    rdData = DEV_ID;
          2'd2:    rdData = DATA_W'(lockVec[rdBlk]);
          default: rdData = '0;
        endcase
      end
      MODE_STATUS: rdData = DATA_W'(statusByte);
      default:     rdData = '0;
    endcase
    dataOe  = ~ceN & ~oeN & rpN;
    dataOut = dataOe ? rdData : '0;
  end

  // R11
  no_locked_write_chk: assert property (@(posedge clk) disable iff (!rpN)
    strobe.memWr |-> !lockVec[opBlk]);

  // R6
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rpN)
    strobe.blkErase |=> (mem[$past(opAddr)] == '1));

  // R7
  program_and_chk: assert property (@(posedge clk) disable iff (!rpN)
    strobe.memWr |=> (mem[$past(opAddr)] == ($past(mem[opAddr]) & $past(opData))));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int              DATA_W         = 16,
  parameter int              ADDR_W         = 6,
  parameter int              BLK_W          = 2,
  parameter int              ERASE_CYCLES   = 40,
  parameter int              WRITE_CYCLES   = 8,
  parameter int              RECOVER_CYCLES = 3,
  parameter logic [DATA_W-1:0] MFR_ID       = 16'h00B0,
  parameter logic [DATA_W-1:0] DEV_ID       = 16'h00E3
) (
  input  logic              clk,
  input  logic              rpN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              ryBy
);

  strobe_t               strobe;
  logic [ADDR_W-1:0]     opAddr;
  logic [DATA_W-1:0]     opData;
  readMode_t             effMode;
  logic [7:0]            statusByte;
  logic [(1<<BLK_W)-1:0] lockVec;

  flash_cmd_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_W(BLK_W),
    .ERASE_CYCLES(ERASE_CYCLES), .WRITE_CYCLES(WRITE_CYCLES),
    .RECOVER_CYCLES(RECOVER_CYCLES)
  ) u_ctrl (
    .clk(clk), .rpN(rpN), .ceN(ceN), .weN(weN), .addr(addr), .dataIn(dataIn),
    .lockVec(lockVec), .strobe(strobe), .opAddr(opAddr), .opData(opData),
    .effMode(effMode), .statusByte(statusByte), .ryBy(ryBy)
  );

  flash_cmd_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_W(BLK_W),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_dp (
    .clk(clk), .rpN(rpN), .ceN(ceN), .oeN(oeN), .addr(addr), .strobe(strobe),
    .opAddr(opAddr), .opData(opData), .effMode(effMode), .statusByte(statusByte),
    .lockVec(lockVec), .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: tb/flash_cmd_if_test.sv
module flash_cmd_if_test;

  localparam int DW = 16;
  localparam int AW = 6;
  localparam int BW = 2;
  localparam int EC = 40;
  localparam int WC = 8;
  localparam int RC = 3;
  localparam int DEPTH = 1 << AW;
  localparam int BWORDS = 1 << (AW - BW);
  localparam logic [DW-1:0] MFR = 16'h00B0;
  localparam logic [DW-1:0] DEV = 16'h00E3;

  logic clk = 1'b0;
  logic rpN, ceN, oeN, weN;
  logic [AW-1:0] addr;
  logic [DW-1:0] dataIn;
  logic [DW-1:0] dataOut;
  logic dataOe, ryBy;

  int checks = 0;
  int errors = 0;
  int busyCnt = 0;
  logic [DW-1:0] model [DEPTH];

  always #10 clk = ~clk;

  flash_cmd_if #(
    .DATA_W(DW), .ADDR_W(AW), .BLK_W(BW), .ERASE_CYCLES(EC),
    .WRITE_CYCLES(WC), .RECOVER_CYCLES(RC), .MFR_ID(MFR), .DEV_ID(DEV)
  ) uut (
    .clk(clk), .rpN(rpN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .ryBy(ryBy)
  );

  always @(negedge clk) if (!ryBy) busyCnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1;
  endtask

  task automatic readWord(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk); addr = a; ceN = 1'b0; oeN = 1'b0;
    #2 v = dataOut;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (!ryBy && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk(req, 32'h1, 32'h0);
  endtask

  task automatic expStatus(input string req, input logic [7:0] exp);
    logic [DW-1:0] v;
    busWrite('0, 16'h0070);
    readWord('0, v);
    chk(req, v, {8'h00, exp});
  endtask

  task automatic eraseBlk(input int b);
    busWrite(AW'(b * BWORDS), 16'h0020);
    busWrite(AW'(b * BWORDS), 16'h00D0);
  endtask

  function automatic logic [DW-1:0] pat1(input int i);
    return 16'h5A3C ^ DW'(i * 16'h0101);
  endfunction
  function automatic logic [DW-1:0] pat2(input int i);
    return 16'hF0F7 ^ DW'(i * 16'h0111);
  endfunction

  task automatic checkAll(input string req);
    logic [DW-1:0] v;
    busWrite('0, 16'h00FF);
    for (int i = 0; i < DEPTH; i++) begin
      readWord(AW'(i), v);
      chk(req, v, model[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    rpN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1; addr = '0; dataIn = '0;
    repeat (4) @(negedge clk);
    // R1 / R4: in reset the outputs stay disabled even when selected
    ceN = 1'b0; oeN = 1'b0; #2;
    chk("R1 ryBy in reset", ryBy, 1);
    chk("R4 oe in reset", dataOe, 0);
    chk("R4 data in reset", dataOut, 0);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk); rpN = 1'b1;
    repeat (RC + 2) @(negedge clk);
    expStatus("R1 status after reset", 8'h80);

    // clear all locks (R11), then erase every block (R6)
    busyCnt = 0;
    busWrite('0, 16'h0060); busWrite('0, 16'h00D0);
    waitIdle("R11");
    chk("R11 lock clear time", busyCnt, WC);
    for (int b = 0; b < (1 << BW); b++) begin
      busyCnt = 0;
      eraseBlk(b);
      waitIdle("R6");
      chk("R6 erase time", busyCnt, EC);
      for (int i = 0; i < BWORDS; i++) model[b * BWORDS + i] = '1;
    end
    checkAll("R6 erased");

    // program sweep (R7), then a second AND pass
    for (int i = 0; i < DEPTH; i++) begin
      busyCnt = 0;
      busWrite(AW'(i), 16'h0040); busWrite(AW'(i), pat1(i));
      waitIdle("R7");
      if (i % 16 == 0) chk("R7 program time", busyCnt, WC);
      model[i] = model[i] & pat1(i);
    end
    checkAll("R7 first pass");
    for (int i = 0; i < DEPTH; i++) begin
      busWrite(AW'(i), 16'h0010); busWrite(AW'(i), pat2(i));
      waitIdle("R7");
      model[i] = model[i] & pat2(i);
    end
    checkAll("R7 AND pass");

    // single block erase leaves others alone (R6)
    eraseBlk(1); waitIdle("R6");
    for (int i = 0; i < BWORDS; i++) model[BWORDS + i] = '1;
    checkAll("R6 other blocks kept");

    // identifier view (R5)
    busWrite('0, 16'h0090);
    readWord(AW'(2 * BWORDS), v);     chk("R5 mfr id", v, MFR);
    readWord(AW'(2 * BWORDS + 1), v); chk("R5 dev id", v, DEV);
    readWord(AW'(2 * BWORDS + 2), v); chk("R5 lock bit", v, 0);
    expStatus("R5 status view", 8'h80);

    // output enable combinations (R4)
    @(negedge clk); ceN = 1'b0; oeN = 1'b1; #2;
    chk("R4 oe high", dataOe, 0); chk("R4 data oe high", dataOut, 0);
    ceN = 1'b1; oeN = 1'b0; #2;
    chk("R4 ce high", dataOe, 0); chk("R4 data ce high", dataOut, 0);
    oeN = 1'b1;

    // status errors (R8)
    busWrite('0, 16'h0033);
    expStatus("R8 unknown code", 8'hB0);
    busWrite('0, 16'h0050);
    expStatus("R8 clear", 8'h80);
    busWrite('0, 16'h0020); busWrite('0, 16'h00FF);
    expStatus("R8 bad confirm", 8'hB0);
    busWrite('0, 16'h0050);

    // erase suspend with nested program (R9, R14)
    busyCnt = 0;
    eraseBlk(0);
    repeat (10) @(negedge clk);
    busWrite('0, 16'h00B0);
    #2 chk("R9 ryBy when suspended", ryBy, 1);
    expStatus("R9 suspended status", 8'hC0);
    busWrite('0, 16'h00FF);
    readWord(AW'(33), v); chk("R9 read other block", v, model[33]);
    busWrite(AW'(40), 16'h0040); busWrite(AW'(40), 16'h0F0F);
    waitIdle("R9");
    model[40] = model[40] & 16'h0F0F;
    expStatus("R9 after nested program", 8'hC0);
    busWrite(AW'(3), 16'h0040); busWrite(AW'(3), 16'h0000);
    #2 chk("R14 no busy", ryBy, 1);
    expStatus("R14 refused", 8'hD0);
    busWrite('0, 16'h0050);
    expStatus("R8 clear keeps suspend", 8'hC0);
    busWrite('0, 16'h00D0);
    waitIdle("R9");
    chk("R9 total busy", busyCnt, EC + WC);
    for (int i = 0; i < BWORDS; i++) model[i] = '1;
    checkAll("R9 erase finished");

    // program suspend (R10)
    busyCnt = 0;
    busWrite(AW'(5), 16'h0040); busWrite(AW'(5), 16'h00F0);
    busWrite('0, 16'h00B0);
    #2 chk("R10 ryBy when suspended", ryBy, 1);
    expStatus("R10 suspended status", 8'h84);
    busWrite('0, 16'h00FF);
    readWord(AW'(20), v); chk("R10 read other word", v, model[20]);
    busWrite('0, 16'h00D0);
    waitIdle("R10");
    chk("R10 total busy", busyCnt, WC);
    model[5] = model[5] & 16'h00F0;
    busWrite('0, 16'h00FF);
    readWord(AW'(5), v); chk("R10 programmed", v, model[5]);

    // busy ignores commands and shows status (R13), CE high during op (R12)
    busyCnt = 0;
    eraseBlk(3);
    busWrite('0, 16'h0090);
    readWord(AW'(48), v); chk("R13 status while busy", v, 16'h0000);
    busWrite(AW'(49), 16'h0040);
    waitIdle("R12");
    chk("R12 completes with CE high", busyCnt, EC);
    for (int i = 0; i < BWORDS; i++) model[48 + i] = '1;
    readWord(AW'(48), v); chk("R13 command ignored", v, 16'h0080);

    // locking (R11)
    busyCnt = 0;
    busWrite(AW'(48), 16'h0060); busWrite(AW'(48), 16'h0001);
    waitIdle("R11");
    chk("R11 lock set time", busyCnt, WC);
    busWrite('0, 16'h0090);
    readWord(AW'(50), v); chk("R11 lock bit set", v, 1);
    busWrite(AW'(48), 16'h0040); busWrite(AW'(48), 16'h0000);
    #2 chk("R11 no busy on locked", ryBy, 1);
    expStatus("R11 locked program", 8'h92);
    busWrite('0, 16'h0050);
    eraseBlk(3);
    #2 chk("R11 no erase busy", ryBy, 1);
    expStatus("R11 locked erase", 8'hA2);
    busWrite('0, 16'h0050);
    checkAll("R11 data unchanged");
    busWrite('0, 16'h0060); busWrite('0, 16'h00D0);
    waitIdle("R11");
    busWrite('0, 16'h0090);
    readWord(AW'(50), v); chk("R11 locks cleared", v, 0);

    // reset abort (R2, R1)
    eraseBlk(2);
    repeat (5) @(negedge clk);
    rpN = 1'b0;
    @(negedge clk); chk("R2 ryBy after abort", ryBy, 1);
    repeat (2) @(negedge clk);
    rpN = 1'b1;
    repeat (RC + 2) @(negedge clk);
    readWord(AW'(1), v); chk("R1 array after reset", v, model[1]);
    expStatus("R2 status after abort", 8'h80);

    // recovery window (R3)
    @(negedge clk); rpN = 1'b0;
    repeat (2) @(negedge clk);
    rpN = 1'b1;
    busWrite('0, 16'h0090);
    readWord(AW'(1), v); chk("R3 ignored in recovery", v, model[1]);
    busWrite('0, 16'h0090);
    readWord(AW'(1), v); chk("R3 accepted later", v, DEV);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule